// File: doc/BRIEF.md
# Dual-Domain Reset Sequencer

This block produces the reset signals for a device with two power domains. One is an always-on standby domain. The other is a working domain that can be switched off. Pin-level reset requests, power-good levels, a standby request and fault events are combined into one standby-state flag. That flag pulls the internal working-domain reset low at once, with no clock needed. When the standby causes clear, the internal reset is released through a two-stage synchronizer on the 32 kHz clock.

The external reset output falls together with the internal reset. Its release waits for a programmable number of 32 kHz edges, counted after the internal reset lets go. The count-done flag then crosses into the bus clock domain, and the output rises on a rising edge of that clock. The delay register sits in the standby domain and is cleared only by the standby reset pin, so a newly written value survives any working-domain reset.

The disk-interface reset follows the internal reset, and is also gated by the attached controller's ready signal in the 66 MHz domain. The boundary-scan reset ignores the standby reset pin and the standby voltage level. This lets scan run while the rest of the device is held in reset.

Top module: `rst_seq_ctrl`

## Requirements
- R1: The delay register takes the value 256 whenever `stby_rst_n` is low, and keeps its value through any working-domain reset (`work_rst_n` low, `stby_req`, `fault_evt`).
- R2: `stby_state` is high when any of these holds: `stby_req` is high, `fault_evt` is high, `work_rst_n` is low, `pg_work` is low, or the standby power-good (`pg_stby_volt` AND `stby_rst_n`) is low.
- R3: While `stby_state` is high, `work_rst_n_int` is low with no clock edge needed. After `stby_state` falls, it rises on the second rising edge of `clk_slow`.
- R4: `rst_out_n` goes low at once, with no clock, whenever `work_rst_n_int` goes low. It is never high while `work_rst_n_int` is low.
- R5: With a programmed delay D of 1 or more, the countdown finishes on the D-th rising edge of `clk_slow` after `work_rst_n_int` rises. `rst_out_n` then rises on the second rising edge of `clk_bus` after that.
- R6: A programmed delay of 0 acts like 1: the countdown finishes on the first `clk_slow` edge after release.
- R7: If the internal reset asserts again during a countdown, `rst_out_n` stays low. The next release counts the full programmed delay again from zero.
- R8: `ide_rst_n` goes low at once with `work_rst_n_int`. It rises on the third rising edge of `clk_fast` after `work_rst_n_int` rises, provided `ata_ready` is high. It stays low while `ata_ready` is low.
- R9: `tap_rst_n` is low exactly when `work_rst_n` is low, `stby_req` is high, `fault_evt` is high or `pg_work` is low. `stby_rst_n` and `pg_stby_volt` do not affect it.
- R10: When `dly_wr_en` is high at a rising edge of `clk_slow`, the delay register loads `dly_wr_data` (20 bits). The next countdown uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | 32 kHz always-on clock |
| clk_bus | input | 1 | Bus-rate clock that aligns the reset-out release |
| clk_fast | input | 1 | 66 MHz clock for the disk-interface reset |
| stby_rst_n | input | 1 | Standby-domain reset pin, active low |
| work_rst_n | input | 1 | Working-domain reset pin, active low |
| pg_stby_volt | input | 1 | Standby voltages in range |
| pg_work | input | 1 | Working-domain power good |
| stby_req | input | 1 | Request to enter the standby state |
| fault_evt | input | 1 | Fault event, level sensitive |
| ata_ready | input | 1 | Disk controller has left reset |
| dly_wr_en | input | 1 | Delay register write strobe (clk_slow) |
| dly_wr_data | input | 20 | Delay value in clk_slow edges |
| work_rst_n_int | output | 1 | Internal working-domain reset, active low |
| rst_out_n | output | 1 | External reset output, active low |
| ide_rst_n | output | 1 | Disk-interface reset, active low |
| tap_rst_n | output | 1 | Boundary-scan controller reset, active low |
| stby_state | output | 1 | Device is in the standby state |

## Verification
A wrong delay register or a stuck countdown shows up only on the release of `rst_out_n`. It appears as an edge too early or too late, measured in whole `clk_slow` periods, and can stay hidden for up to D slow cycles. That is why each release is timed to the exact slow edge and the exact bus edge. A broken cause combination or asynchronous clear shows at once on `stby_state`, `tap_rst_n` or the reset outputs, within the same time step. A lost synchronizer stage shifts a release by one clock of the domain concerned.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;

  localparam int unsigned RSQ_DLY_W   = 20;
  localparam int unsigned RSQ_DLY_DEF = 256;

  // Countdown is finished once the number of elapsed edges reaches the limit;
  // a limit of zero finishes on the first edge like a limit of one.
  function automatic logic delay_reached(input logic [31:0] elapsed,
                                         input logic [31:0] limit);
    return (elapsed >= limit);
  endfunction

  // Causes that reset the boundary-scan controller (standby pin excluded).
  function automatic logic scan_cause(input logic req, input logic flt,
                                      input logic pg_w, input logic wrst_n);
    return req | flt | ~pg_w | ~wrst_n;
  endfunction

endpackage

// File: rtl/rst_sync_chain.sv
`timescale 1ns/1ps
module rst_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg[gi] <= 1'b0;
        else if (gi == 0) stg[gi] <= d;
        else stg[gi] <= stg[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rst_delay_reg.sv
`timescale 1ns/1ps
module rst_delay_reg #(
  parameter int unsigned DLY_W   = 20,
  parameter int unsigned DLY_DEF = 256
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wr_en,
  input  logic [DLY_W-1:0] wr_data,
  output logic [DLY_W-1:0] dly_q
);
  localparam logic [DLY_W-1:0] RESET_VAL = DLY_W'(DLY_DEF);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    dly_q <= RESET_VAL;
    else if (wr_en) dly_q <= wr_data;
  end

  // R10 / R1: value only changes through a write
  assert_hold_R10: assert property (@(posedge clk) disable iff (!arst_n)
    !$past(wr_en) |-> $stable(dly_q));
endmodule

// File: rtl/rst_delay_timer.sv
`timescale 1ns/1ps
module rst_delay_timer
  import rst_seq_pkg::*;
#(
  parameter int unsigned DLY_W = 20
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [DLY_W-1:0] limit,
  output logic             done
);
  logic [DLY_W-1:0] elapsed;
  logic [DLY_W-1:0] elapsed_inc;
  logic             reach_now;

  assign elapsed_inc = elapsed + 1'b1;
  assign reach_now   = delay_reached(32'(elapsed_inc), 32'(limit));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      elapsed <= '0;
      done    <= 1'b0;
    end else if (!done) begin
      elapsed <= elapsed_inc;
      if (reach_now) done <= 1'b1;
    end
  end

  // R5: completion only once the programmed number of edges has elapsed
  assert_done_count_R5: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(done) |-> (elapsed >= limit));
  // R7: completion is held until the internal reset restarts the count
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!arst_n)
    done |=> done);
endmodule

// File: rtl/rst_seq_ctrl.sv
`timescale 1ns/1ps
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned DLY_W       = RSQ_DLY_W,
  parameter int unsigned DLY_DEF     = RSQ_DLY_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_slow,
  input  logic             clk_bus,
  input  logic             clk_fast,
  input  logic             stby_rst_n,
  input  logic             work_rst_n,
  input  logic             pg_stby_volt,
  input  logic             pg_work,
  input  logic             stby_req,
  input  logic             fault_evt,
  input  logic             ata_ready,
  input  logic             dly_wr_en,
  input  logic [DLY_W-1:0] dly_wr_data,
  output logic             work_rst_n_int,
  output logic             rst_out_n,
  output logic             ide_rst_n,
  output logic             tap_rst_n,
  output logic             stby_state
);
  // named internal events
  logic             pg_stby_int;
  logic             scan_hold;
  logic             release_ok;
  logic [DLY_W-1:0] dly_cur;
  logic             count_done;
  logic             work_ok_fast;
  logic             ide_q;

  assign pg_stby_int = pg_stby_volt & stby_rst_n;
  assign scan_hold   = scan_cause(stby_req, fault_evt, pg_work, work_rst_n);
  assign stby_state  = scan_hold | ~pg_stby_int;
  assign tap_rst_n   = ~scan_hold;
  assign release_ok  = ~stby_state;

  rst_delay_reg #(.DLY_W(DLY_W), .DLY_DEF(DLY_DEF)) u_dly (
    .clk(clk_slow), .arst_n(stby_rst_n), .wr_en(dly_wr_en),
    .wr_data(dly_wr_data), .dly_q(dly_cur));

  rst_sync_chain #(.STAGES(SYNC_STAGES)) u_work_sync (
    .clk(clk_slow), .arst_n(release_ok), .d(1'b1), .q(work_rst_n_int));

  rst_delay_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk_slow), .arst_n(work_rst_n_int), .limit(dly_cur), .done(count_done));

  rst_sync_chain #(.STAGES(SYNC_STAGES)) u_out_sync (
    .clk(clk_bus), .arst_n(work_rst_n_int), .d(count_done), .q(rst_out_n));

  rst_sync_chain #(.STAGES(SYNC_STAGES)) u_fast_sync (
    .clk(clk_fast), .arst_n(work_rst_n_int), .d(1'b1), .q(work_ok_fast));

  always_ff @(posedge clk_fast or negedge work_rst_n_int) begin
    if (!work_rst_n_int) ide_q <= 1'b0;
    else                 ide_q <= work_ok_fast & ata_ready;
  end
  assign ide_rst_n = ide_q;

  // R3: standby always holds the internal working reset
  assert_stby_holds_R3: assert property (@(posedge clk_slow) disable iff (!stby_rst_n)
    stby_state |-> !work_rst_n_int);
  // R4: reset-out never released while internal reset is active
  assert_out_follows_R4: assert property (@(posedge clk_bus) disable iff (!stby_rst_n)
    rst_out_n |-> work_rst_n_int);
  // R5: reset-out release is preceded by the slow-domain count completing
  assert_out_after_count_R5: assert property (@(posedge clk_bus) disable iff (!work_rst_n_int)
    $rose(rst_out_n) |-> count_done);
  // R8: disk reset released only with the internal reset released
  assert_ide_follows_R8: assert property (@(posedge clk_fast) disable iff (!stby_rst_n)
    ide_rst_n |-> work_rst_n_int);
endmodule

// File: tb/rst_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_seq_ctrl_tb_top;
  logic clk_slow = 1'b0, clk_bus = 1'b0, clk_fast = 1'b0;
  logic stby_rst_n, work_rst_n, pg_stby_volt, pg_work, stby_req, fault_evt, ata_ready;
  logic dly_wr_en;
  logic [19:0] dly_wr_data;
  logic work_rst_n_int, rst_out_n, ide_rst_n, tap_rst_n, stby_state;

  int n_total = 0;
  int n_fail  = 0;
  bit done_flag = 0;

  // 50 MHz bus clock; scaled slow clock; 66 MHz fast clock
  always #10 clk_bus = ~clk_bus;
  always #7.5 clk_fast = ~clk_fast;
  initial begin
    #3;
    forever #200 clk_slow = ~clk_slow;
  end

  rst_seq_ctrl dut_i (
    .clk_slow(clk_slow), .clk_bus(clk_bus), .clk_fast(clk_fast),
    .stby_rst_n(stby_rst_n), .work_rst_n(work_rst_n), .pg_stby_volt(pg_stby_volt),
    .pg_work(pg_work), .stby_req(stby_req), .fault_evt(fault_evt), .ata_ready(ata_ready),
    .dly_wr_en(dly_wr_en), .dly_wr_data(dly_wr_data),
    .work_rst_n_int(work_rst_n_int), .rst_out_n(rst_out_n), .ide_rst_n(ide_rst_n),
    .tap_rst_n(tap_rst_n), .stby_state(stby_state));

  // {stby_rst_n, pg_stby_volt, pg_work, work_rst_n, stby_req, fault_evt, exp_stby, exp_tap_n}
  localparam logic [7:0] VEC [8] = '{
    8'b111100_01, 8'b011100_11, 8'b101100_11, 8'b110100_10,
    8'b111000_10, 8'b111110_10, 8'b111101_10, 8'b010000_10 };

  task automatic chk(input string req, input logic act, input logic exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  endtask

  task automatic write_delay(input logic [19:0] v);
    @(negedge clk_slow); dly_wr_en = 1'b1; dly_wr_data = v;
    @(negedge clk_slow); dly_wr_en = 1'b0;
  endtask

  task automatic enter_standby();
    @(negedge clk_slow); stby_req = 1'b1;
    #1 chk("R4", rst_out_n, 1'b0);
  endtask

  // release from standby and time the reset-out release for effective delay d
  task automatic release_measure(input int d, input string tag);
    @(negedge clk_slow); stby_req = 1'b0;
    @(posedge clk_slow); #1 chk("R3", work_rst_n_int, 1'b0);
    @(posedge clk_slow); #1 chk("R3", work_rst_n_int, 1'b1);
    repeat (d - 1) @(posedge clk_slow);
    #1 chk(tag, rst_out_n, 1'b0);
    @(posedge clk_slow);
    @(posedge clk_bus); #1 chk(tag, rst_out_n, 1'b0);
    @(posedge clk_bus); #1 chk(tag, rst_out_n, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk_bus);
    n_total++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    stby_rst_n = 0; pg_stby_volt = 1; pg_work = 1; work_rst_n = 1;
    stby_req = 0; fault_evt = 0; ata_ready = 0; dly_wr_en = 0; dly_wr_data = '0;
    repeat (3) @(posedge clk_slow); #1;
    chk("R2", stby_state, 1'b1);
    chk("R3", work_rst_n_int, 1'b0);
    chk("R4", rst_out_n, 1'b0);
    chk("R8", ide_rst_n, 1'b0);
    chk("R9", tap_rst_n, 1'b1);

    // cause combinations (R2, R9, R3)
    for (int i = 0; i < 8; i++) begin
      {stby_rst_n, pg_stby_volt, pg_work, work_rst_n, stby_req, fault_evt} = VEC[i][7:2];
      #5;
      chk("R2", stby_state, VEC[i][1]);
      chk("R9", tap_rst_n, VEC[i][0]);
      if (VEC[i][1]) chk("R3", work_rst_n_int, 1'b0);
    end

    // hold in standby by request, everything else nominal
    stby_req = 1; stby_rst_n = 1; pg_stby_volt = 1; pg_work = 1; work_rst_n = 1; fault_evt = 0;
    ata_ready = 1;
    repeat (2) @(posedge clk_slow);
    release_measure(256, "R1");           // default delay
    enter_standby();

    write_delay(20'd5);
    release_measure(5, "R10");
    // working reset pin: scan reset asserts, delay survives (R1, R9)
    @(negedge clk_slow); work_rst_n = 0; stby_req = 1;
    #1 chk("R9", tap_rst_n, 1'b0); chk("R4", rst_out_n, 1'b0);
    @(negedge clk_slow); work_rst_n = 1;
    #1 chk("R9", tap_rst_n, 1'b0);
    release_measure(5, "R1");

    // re-assertion during countdown (R7)
    enter_standby();
    @(negedge clk_slow); stby_req = 0;
    repeat (4) @(posedge clk_slow);
    @(negedge clk_slow); stby_req = 1;
    #1 chk("R7", rst_out_n, 1'b0); chk("R7", work_rst_n_int, 1'b0);
    repeat (3) @(posedge clk_slow);
    release_measure(5, "R7");

    // immediate assertion by fault mid bus cycle (R4, R3, R8)
    @(posedge clk_bus); #4; fault_evt = 1;
    #1 chk("R4", rst_out_n, 1'b0); chk("R3", work_rst_n_int, 1'b0); chk("R8", ide_rst_n, 1'b0);
    @(negedge clk_slow); fault_evt = 0; stby_req = 1; ata_ready = 0;

    // disk reset gated by controller ready (R8)
    @(negedge clk_slow); stby_req = 0;
    @(posedge work_rst_n_int);
    repeat (5) @(posedge clk_fast); #1 chk("R8", ide_rst_n, 1'b0);
    ata_ready = 1;
    @(posedge clk_fast); #1 chk("R8", ide_rst_n, 1'b1);
    enter_standby();
    chk("R8", ide_rst_n, 1'b0);
    @(negedge clk_slow); stby_req = 0;
    @(posedge work_rst_n_int);
    repeat (2) @(posedge clk_fast); #1 chk("R8", ide_rst_n, 1'b0);
    @(posedge clk_fast); #1 chk("R8", ide_rst_n, 1'b1);
    enter_standby();

    // zero delay (R6)
    write_delay(20'd0);
    release_measure(1, "R6");
    enter_standby();

    // standby reset pin restores the default (R1)
    @(negedge clk_slow); stby_rst_n = 0;
    #1 chk("R2", stby_state, 1'b1); chk("R9", tap_rst_n, 1'b0);
    @(negedge clk_slow); stby_rst_n = 1;
    release_measure(256, "R1");

    report();
  end
endmodule